// File: doc/BRIEF.md
# Packed-Flag Byte Arithmetic Unit

This block is the arithmetic slice of a small 8-bit processor datapath. It is purely combinational: two operands, an operation code and the flag byte currently held by the processor go in, and the arithmetic result and the next flag byte come out in the same cycle. The surrounding core decides whether to write either of them back.

Four status bits are packed into the top nibble of the flag byte: zero, subtract, half-carry and carry. The half-carry bit tracks a carry or borrow at the boundary between the low and high nibble, which later decimal correction logic needs. Increment and decrement share the adder with add and subtract but deliberately leave the carry bit alone. A pass-through operation moves the second operand to the result without touching any flag.

The adder core can be built as an explicit bit-serial ripple chain or as two wide additions split at the nibble boundary, chosen by a parameter. Both produce the same ports and behaviour.

Top module: `nfa_core`

## Requirements
- R1: The operation code `op_sel` selects add (0), subtract (1), increment of `a_in` (2), decrement of `a_in` (3) and pass-through (4); increment and decrement ignore `b_in`.
- R2: The flag byte holds zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4; bits 3 to 0 of `flags_out` are always 0, whatever `flags_in` holds.
- R3: For add, subtract, increment and decrement, bit 7 of `flags_out` is 1 exactly when `result_out` is 0x00.
- R4: Bit 6 of `flags_out` is 1 after subtract and decrement and 0 after add and increment.
- R5: Add returns (a + b) mod 256; bit 5 is 1 when the low nibbles of a and b sum above 0xF, bit 4 is 1 when the full sum exceeds 0xFF.
- R6: Subtract returns (a − b) mod 256; bit 5 is 1 when the low nibble of a is below that of b, bit 4 is 1 when a is below b.
- R7: Increment and decrement set bit 5 from the nibble carry or borrow of a ± 1 and copy bit 4 of `flags_in` to bit 4 of `flags_out`.
- R8: Pass-through returns `b_in` and copies bits 7 to 4 of `flags_in` unchanged.
- R9: Codes 5, 6 and 7 behave exactly as pass-through.
- R10: Results wrap: 0xFF incremented gives 0x00 with zero and half-carry set; 0x00 decremented gives 0xFF with subtract and half-carry set; 0x0A incremented from flag byte 0xA0 gives 0x0B and flag byte 0x00; 0x0B decremented from 0x00 gives 0x0A and 0x40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | DATA_W | First operand; the operand of increment and decrement |
| b_in | input | DATA_W | Second operand; the value moved by pass-through |
| op_sel | input | 3 | Operation code |
| flags_in | input | FLAG_W | Flag byte currently held by the processor |
| result_out | output | DATA_W | Arithmetic result |
| flags_out | output | FLAG_W | Next flag byte |

## Verification
The bench instantiates the block twice at the default 8-bit data width and flag layout, once with the ripple-chain adder and once with the nibble-split adder, and compares both against the same reference on every vector. Keeping the width at 8 makes every operand pair of add and subtract reachable exhaustively, so every nibble boundary and every wrap point is hit in both adder variants. Increment and decrement are swept over all operands with the incoming carry bit forced both ways, and pass-through and the unused codes are driven with random flag bytes whose low nibble is non-zero.

// File: rtl/nfa_pkg.sv
package nfa_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      NFA_ADD  = 3'd0,
      NFA_SUB  = 3'd1,
      NFA_INC  = 3'd2,
      NFA_DEC  = 3'd3,
      NFA_PASS = 3'd4
   } nfa_op_e;

   typedef struct packed {
      logic use_one;   // second adder operand is the constant one
      logic invert;    // adder operand is complemented (subtract forms)
      logic carry_in;  // carry into bit 0
      logic is_arith;  // result and flags come from the adder
      logic keep_c;    // carry flag is held from the incoming byte
      logic sub_flag;  // value of the subtract flag
   } nfa_ctl_t;

   localparam int ADDER_RIPPLE = 0;
   localparam int ADDER_SPLIT  = 1;

endpackage

// File: rtl/nfa_decode.sv
module nfa_decode
   import nfa_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   output nfa_ctl_t        ctl_o
);

   always_comb begin
      ctl_o = '0;
      case (op_i)
         NFA_ADD: begin
            ctl_o.is_arith = 1'b1;
         end
         NFA_SUB: begin
            ctl_o.is_arith = 1'b1;
            ctl_o.invert   = 1'b1;
            ctl_o.carry_in = 1'b1;
            ctl_o.sub_flag = 1'b1;
         end
         NFA_INC: begin
            ctl_o.is_arith = 1'b1;
            ctl_o.use_one  = 1'b1;
            ctl_o.keep_c   = 1'b1;
         end
         NFA_DEC: begin
            ctl_o.is_arith = 1'b1;
            ctl_o.use_one  = 1'b1;
            ctl_o.invert   = 1'b1;
            ctl_o.carry_in = 1'b1;
            ctl_o.keep_c   = 1'b1;
            ctl_o.sub_flag = 1'b1;
         end
         default: begin
            ctl_o = '0;
         end
      endcase
   end

endmodule

// File: rtl/nfa_adder.sv
module nfa_adder
   import nfa_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4,
   parameter int STYLE  = ADDER_RIPPLE
) (
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              half_o,
   output logic              cout_o
);

   localparam int HI_W = DATA_W - NIB_W;

   if (NIB_W < 1 || NIB_W >= DATA_W) begin : g_bad_nib
      $error("nfa_adder: NIB_W must lie strictly inside DATA_W");
   end
   if (STYLE != ADDER_RIPPLE && STYLE != ADDER_SPLIT) begin : g_bad_style
      $error("nfa_adder: unknown STYLE");
   end

   if (STYLE == ADDER_RIPPLE) begin : g_ripple
      logic [DATA_W:0] chain;
      assign chain[0] = cin_i;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign sum_o[i]    = x_i[i] ^ y_i[i] ^ chain[i];
         assign chain[i+1]  = (x_i[i] & y_i[i]) | (chain[i] & (x_i[i] ^ y_i[i]));
      end
      assign half_o = chain[NIB_W];
      assign cout_o = chain[DATA_W];

      // R5
      always_comb begin
         ripple_sum_chk: assert ({cout_o, sum_o} ==
                                 ({1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i}))
            else $error("ripple chain disagrees with wide sum");
      end
   end else begin : g_split
      logic [NIB_W:0] lo_sum;
      logic [HI_W:0]  hi_sum;
      assign lo_sum = {1'b0, x_i[NIB_W-1:0]} + {1'b0, y_i[NIB_W-1:0]}
                    + {{NIB_W{1'b0}}, cin_i};
      assign hi_sum = {1'b0, x_i[DATA_W-1:NIB_W]} + {1'b0, y_i[DATA_W-1:NIB_W]}
                    + {{HI_W{1'b0}}, lo_sum[NIB_W]};
      assign sum_o  = {hi_sum[HI_W-1:0], lo_sum[NIB_W-1:0]};
      assign half_o = lo_sum[NIB_W];
      assign cout_o = hi_sum[HI_W];
   end

endmodule

// File: rtl/nfa_flagpack.sv
module nfa_flagpack
   import nfa_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int FLAG_W = 8,
   parameter int Z_POS  = 7,
   parameter int N_POS  = 6,
   parameter int H_POS  = 5,
   parameter int C_POS  = 4
) (
   input  nfa_ctl_t          ctl_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic              half_i,
   input  logic              carry_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [FLAG_W-1:0] flags_o
);

   logic z_nxt, n_nxt, h_nxt, c_nxt;

   always_comb begin
      if (ctl_i.is_arith) begin
         z_nxt = (res_i == '0);
         n_nxt = ctl_i.sub_flag;
         h_nxt = half_i;
         c_nxt = ctl_i.keep_c ? flags_i[C_POS] : carry_i;
      end else begin
         z_nxt = flags_i[Z_POS];
         n_nxt = flags_i[N_POS];
         h_nxt = flags_i[H_POS];
         c_nxt = flags_i[C_POS];
      end
   end

   for (genvar i = 0; i < FLAG_W; i++) begin : g_fbit
      if (i == Z_POS) begin : g_z
         assign flags_o[i] = z_nxt;
      end else if (i == N_POS) begin : g_n
         assign flags_o[i] = n_nxt;
      end else if (i == H_POS) begin : g_h
         assign flags_o[i] = h_nxt;
      end else if (i == C_POS) begin : g_c
         assign flags_o[i] = c_nxt;
      end else begin : g_zero
         assign flags_o[i] = 1'b0;
      end
   end

   // R4
   always_comb begin
      if (ctl_i.is_arith) begin
         sub_flag_chk: assert (flags_o[N_POS] == ctl_i.sub_flag)
            else $error("subtract flag does not follow operation");
      end
   end

endmodule

// File: rtl/nfa_core.sv
module nfa_core
   import nfa_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4,
   parameter int FLAG_W = 8,
   parameter int Z_POS  = 7,
   parameter int N_POS  = 6,
   parameter int H_POS  = 5,
   parameter int C_POS  = 4,
   parameter int STYLE  = ADDER_RIPPLE
) (
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic [OP_W-1:0]   op_sel,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [DATA_W-1:0] result_out,
   output logic [FLAG_W-1:0] flags_out
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   if (DATA_W < 2) begin : g_bad_w
      $error("nfa_core: DATA_W too small");
   end
   if (Z_POS >= FLAG_W || N_POS >= FLAG_W || H_POS >= FLAG_W || C_POS >= FLAG_W)
   begin : g_bad_pos
      $error("nfa_core: flag position outside flag byte");
   end
   if (Z_POS == N_POS || Z_POS == H_POS || Z_POS == C_POS ||
       N_POS == H_POS || N_POS == C_POS || H_POS == C_POS) begin : g_dup_pos
      $error("nfa_core: flag positions overlap");
   end

   nfa_ctl_t          ctl;
   logic [DATA_W-1:0] y_sel, y_add, sum;
   logic              half_raw, cout_raw, half_flag, carry_flag;

   nfa_decode u_dec (
      .op_i  (op_sel),
      .ctl_o (ctl)
   );

   assign y_sel = ctl.use_one ? ONE : b_in;
   assign y_add = ctl.invert ? ~y_sel : y_sel;

   nfa_adder #(
      .DATA_W (DATA_W),
      .NIB_W  (NIB_W),
      .STYLE  (STYLE)
   ) u_add (
      .x_i    (a_in),
      .y_i    (y_add),
      .cin_i  (ctl.carry_in),
      .sum_o  (sum),
      .half_o (half_raw),
      .cout_o (cout_raw)
   );

   // Subtract forms report a borrow: the complement of the carry out.
   assign half_flag  = ctl.invert ? ~half_raw : half_raw;
   assign carry_flag = ctl.invert ? ~cout_raw : cout_raw;
   assign result_out = ctl.is_arith ? sum : b_in;

   nfa_flagpack #(
      .DATA_W (DATA_W),
      .FLAG_W (FLAG_W),
      .Z_POS  (Z_POS),
      .N_POS  (N_POS),
      .H_POS  (H_POS),
      .C_POS  (C_POS)
   ) u_flg (
      .ctl_i   (ctl),
      .res_i   (result_out),
      .half_i  (half_flag),
      .carry_i (carry_flag),
      .flags_i (flags_in),
      .flags_o (flags_out)
   );

   always_comb begin
      if (op_sel <= OP_W'(NFA_DEC)) begin
         // R3
         zero_flag_chk: assert (flags_out[Z_POS] == (result_out == '0))
            else $error("zero flag disagrees with result");
      end
      if (op_sel == OP_W'(NFA_INC) || op_sel == OP_W'(NFA_DEC)) begin
         // R7
         carry_keep_chk: assert (flags_out[C_POS] == flags_in[C_POS])
            else $error("carry flag moved on increment or decrement");
      end
      if (op_sel >= OP_W'(NFA_PASS)) begin
         // R8
         pass_thru_chk: assert (result_out == b_in &&
                                flags_out[Z_POS] == flags_in[Z_POS] &&
                                flags_out[N_POS] == flags_in[N_POS] &&
                                flags_out[H_POS] == flags_in[H_POS] &&
                                flags_out[C_POS] == flags_in[C_POS])
            else $error("pass-through altered result or flags");
      end
   end

endmodule

// File: tb/tb_nfa_core.sv
`timescale 1ns/1ps
module tb_nfa_core;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [7:0] a, b, fi;
   logic [2:0] op;
   logic [7:0] res0, flg0, res1, flg1;
   int checks = 0;
   int failures = 0;
   bit done = 0;

   nfa_core #(.STYLE(0)) dut (
      .a_in(a), .b_in(b), .op_sel(op), .flags_in(fi),
      .result_out(res0), .flags_out(flg0));

   nfa_core #(.STYLE(1)) dut_alt (
      .a_in(a), .b_in(b), .op_sel(op), .flags_in(fi),
      .result_out(res1), .flags_out(flg1));

   function automatic logic [7:0] exp_res(input logic [7:0] x, y, input logic [2:0] o);
      case (o)
         3'd0: return x + y;
         3'd1: return x - y;
         3'd2: return x + 8'd1;
         3'd3: return x - 8'd1;
         default: return y;
      endcase
   endfunction

   function automatic logic [7:0] exp_flg(input logic [7:0] x, y, f, input logic [2:0] o);
      logic [7:0] r;
      logic z, n, h, c;
      r = exp_res(x, y, o);
      z = (r == 8'd0);
      case (o)
         3'd0: begin n = 0; h = ({1'b0, x[3:0]} + {1'b0, y[3:0]}) > 5'd15;
                     c = ({1'b0, x} + {1'b0, y}) > 9'd255; end
         3'd1: begin n = 1; h = x[3:0] < y[3:0]; c = x < y; end
         3'd2: begin n = 0; h = (x[3:0] == 4'hF); c = f[4]; end
         3'd3: begin n = 1; h = (x[3:0] == 4'h0); c = f[4]; end
         default: return {f[7:4], 4'h0};
      endcase
      return {z, n, h, c, 4'h0};
   endfunction

   task automatic apply(input string tag, input logic [7:0] x, y, f, input logic [2:0] o);
      logic [7:0] er, ef;
      a = x; b = y; fi = f; op = o;
      #1;
      er = exp_res(x, y, o);
      ef = exp_flg(x, y, f, o);
      checks++;
      if (res0 !== er || flg0 !== ef) begin
         failures++;
         $display("FAIL %s ripple op=%0d a=%h b=%h fi=%h: got res=%h flg=%h exp res=%h flg=%h",
                  tag, o, x, y, f, res0, flg0, er, ef);
      end
      checks++;
      if (res1 !== er || flg1 !== ef) begin
         failures++;
         $display("FAIL %s split op=%0d a=%h b=%h fi=%h: got res=%h flg=%h exp res=%h flg=%h",
                  tag, o, x, y, f, res1, flg1, er, ef);
      end
   endtask

   task automatic fixed(input string tag, input logic [7:0] x, f, input logic [2:0] o,
                        input logic [7:0] er, ef);
      a = x; b = 8'h5C; fi = f; op = o;
      #1;
      checks++;
      if (res0 !== er || flg0 !== ef || res1 !== er || flg1 !== ef) begin
         failures++;
         $display("FAIL %s op=%0d a=%h: got res=%h/%h flg=%h/%h exp res=%h flg=%h",
                  tag, o, x, res0, res1, flg0, flg1, er, ef);
      end
   endtask

   initial begin
      void'($urandom(32'h1D2C));
      a = 0; b = 0; fi = 0; op = 0;
      @(negedge clk);
      // idle state: add of zeros gives zero with only Z set (R3, R2)
      checks++;
      if (res0 !== 8'h00 || flg0 !== 8'h80) begin
         failures++;
         $display("FAIL R3 idle: got res=%h flg=%h exp res=00 flg=80", res0, flg0);
      end
      // R10 directed corners
      fixed("R10", 8'h0A, 8'hA0, 3'd2, 8'h0B, 8'h00);
      fixed("R10", 8'h0B, 8'h00, 3'd3, 8'h0A, 8'h40);
      fixed("R10", 8'hFF, 8'h00, 3'd2, 8'h00, 8'hA0);
      fixed("R10", 8'hFF, 8'h1F, 3'd2, 8'h00, 8'hB0);
      fixed("R10", 8'h00, 8'h00, 3'd3, 8'hFF, 8'h60);
      fixed("R10", 8'h00, 8'hFF, 3'd3, 8'hFF, 8'h70);
      // R1 R7: b ignored by inc/dec, carry held
      fixed("R7", 8'h7F, 8'h10, 3'd2, 8'h80, 8'h30);
      // R5 R4 exhaustive add
      for (int x = 0; x < 256; x++)
         for (int y = 0; y < 256; y++)
            apply("R5", 8'(x), 8'(y), 8'($urandom), 3'd0);
      // R6 R4 exhaustive subtract
      for (int x = 0; x < 256; x++)
         for (int y = 0; y < 256; y++)
            apply("R6", 8'(x), 8'(y), 8'($urandom), 3'd1);
      // R7 increment and decrement, carry in both states
      for (int x = 0; x < 256; x++) begin
         apply("R7", 8'(x), 8'($urandom), 8'h00, 3'd2);
         apply("R7", 8'(x), 8'($urandom), 8'hFF, 3'd2);
         apply("R7", 8'(x), 8'($urandom), 8'h00, 3'd3);
         apply("R7", 8'(x), 8'($urandom), 8'hFF, 3'd3);
      end
      // R8 pass-through, R9 unused codes, R2 low nibble forced clear
      for (int k = 0; k < 1000; k++) begin
         apply("R8", 8'($urandom), 8'($urandom), 8'($urandom) | 8'h0F, 3'd4);
         apply("R9", 8'($urandom), 8'($urandom), 8'($urandom), 3'(5 + (k % 3)));
         apply("R2", 8'($urandom), 8'($urandom), 8'($urandom) | 8'h0F, 3'(k % 4));
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule